// File: doc/BRIEF.md
# Descriptor-Chained Audio Sample DMA Channel

This block is one bus-master channel that streams audio samples between system memory and a codec sample port. Software builds a chain of descriptors in memory and writes the chain's start address into the channel. It then sets the run state. The channel fetches each descriptor, which is a buffer base word followed by a size/flags word. It then moves the buffer one 32-bit word at a time. In playback it reads memory and presents the words on a valid/ready output stream. In record it accepts words from a valid/ready input stream and writes them to memory.

Descriptor flags control the walk. A jump entry redirects fetching to another descriptor address, so a chain can loop back to its start and run as a ring. An end-of-page entry sets a status bit when its data is done, which raises the interrupt line. An end-of-table entry completes its data and then returns the channel to the disabled state. The run state can be paused separately from disable. A paused channel holds its exact position and resumes from it when run is written again. A memory error, or a descriptor too short to hold one word, stops the channel and sets an error bit.

Top module: `dmac_channel`

## Requirements
- R1: After reset, irq is low, every register reads zero, mem_req is low and neither stream handshakes.
- R2: Register addresses are 0 = command, 1 = status, 2 = descriptor-table address and 3 = current pointer. The command register reads back bit 3 = direction (1 = codec to memory), bit 2 = byte order (1 = big endian) and bits 1:0 = run state.
- R3: Writing run state 01 while the channel is idle starts a fetch of the descriptor at the table address. The base word is read first and the flags word at +4 second. In the flags word, bit 31 = end of table, bit 30 = end of page, bit 29 = jump, and bits 16:0 = byte count. The count moves count/4 words.
- R4: In playback (direction 0), the words at base, base+4, and so on are read from memory and presented in order on the output stream. Each word is held until it is accepted.
- R5: Once mem_req is raised, it stays high with stable address, write flag and write data until mem_ack.
- R6: In record (direction 1), each accepted input word is written to memory at consecutive addresses starting at the descriptor base.
- R7: With byte order 1, the four bytes of every data word are reversed in both directions. Descriptor words are never reversed.
- R8: After the last word of an end-of-page descriptor, status bit 0 sets and irq rises. The channel then fetches the descriptor at +8 without waiting for software.
- R9: A jump descriptor moves no data. Its base word becomes the address of the next descriptor fetched.
- R10: An end-of-table descriptor completes its data and sets status bit 0. The run state then reads 00 and no further memory requests are made.
- R11: Reading status returns its bits and clears them, and irq falls on the next cycle. irq stays high until that read.
- R12: The current-pointer register holds the memory address of the next data word to be read or written.
- R13: Run state 11 (pause) stops new memory requests and both stream handshakes. Writing 01 again resumes from the held position without refetching. Writing 00 halts the channel.
- R14: A memory error response, or a non-jump byte count below 4, sets status bit 1, returns the run state to 00 and stops the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status at address 1) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq | output | 1 | Interrupt request, high while any status bit is set |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory request completed this cycle |
| mem_err | input | 1 | Completed request failed (valid with mem_ack) |
| mem_rdata | input | 32 | Memory read data (valid with mem_ack) |
| smp_out_valid | output | 1 | Playback sample valid |
| smp_out_ready | input | 1 | Codec accepts the playback sample |
| smp_out_data | output | 32 | Playback sample word |
| smp_in_valid | input | 1 | Record sample valid |
| smp_in_ready | output | 1 | Channel accepts the record sample |
| smp_in_data | input | 32 | Record sample word |

## Verification
The bound checker checks several rules on every cycle. A raised memory request holds its fields until acknowledged. A stalled playback word stays stable. Pause silences both streams and blocks new requests. An error always forces the run state to disabled. The interrupt line rises only from a status event and drops only after a status read. The descriptor walk order, the jump back to the table start, the +8 step, resuming after pause at the held pointer, byte reversal and the two error causes are shown only by the bench scenarios. In those scenarios, the bench's memory and stream models compare each memory access and each stream handshake against queues built from the requirements.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DBASE,
        ST_DSIZE,
        ST_MRD,
        ST_SOUT,
        ST_SIN,
        ST_MWR
    } dmac_st_e;

    // flag positions in the descriptor size word
    localparam int FLG_EOT = 31;
    localparam int FLG_EOP = 30;
    localparam int FLG_JMP = 29;

    // run-state codes
    localparam logic [1:0] MODE_OFF   = 2'b00;
    localparam logic [1:0] MODE_RUN   = 2'b01;
    localparam logic [1:0] MODE_PAUSE = 2'b11;

    // register addresses
    localparam logic [1:0] RA_CMD = 2'd0;
    localparam logic [1:0] RA_STS = 2'd1;
    localparam logic [1:0] RA_TBL = 2'd2;
    localparam logic [1:0] RA_PTR = 2'd3;

endpackage

// File: rtl/dmac_swap.sv
module dmac_swap #(
    parameter int DATA_W = 32
) (
    input  logic              big_end,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int NB = DATA_W / 8;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        assign dout[8*i +: 8] = big_end ? din[8*(NB-1-i) +: 8] : din[8*i +: 8];
    end
endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        eng_idle,
    input  logic        ev_eop,
    input  logic        ev_err,
    input  logic        ev_stop,
    input  logic [31:0] cur_ptr,
    output logic [1:0]  mode,
    output logic        dir,
    output logic        big_end,
    output logic [31:0] tbl_addr,
    output logic        start,
    output logic        irq
);
    typedef struct packed {
        logic [1:0]  mode;
        logic        be;
        logic        dir;
        logic [1:0]  sts;
        logic [31:0] tbl;
    } regs_t;

    regs_t q, d;
    logic  cmd_wr;

    always_comb begin
        d      = q;
        cmd_wr = reg_wr && (reg_addr == RA_CMD);
        if (cmd_wr) begin
            d.mode = reg_wdata[1:0];
            d.be   = reg_wdata[2];
            d.dir  = reg_wdata[3];
        end
        if (reg_wr && (reg_addr == RA_TBL)) begin
            d.tbl = {reg_wdata[31:2], 2'b00};
        end
        if (ev_stop) begin
            d.mode = MODE_OFF;
        end
        if (reg_rd && (reg_addr == RA_STS)) begin
            d.sts = 2'b00;
        end
        d.sts = d.sts | {ev_err, ev_eop};

        start = cmd_wr && (reg_wdata[1:0] == MODE_RUN) && eng_idle;

        unique case (reg_addr)
            RA_CMD:  reg_rdata = {28'd0, q.dir, q.be, q.mode};
            RA_STS:  reg_rdata = {30'd0, q.sts};
            RA_TBL:  reg_rdata = q.tbl;
            default: reg_rdata = cur_ptr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mode     = q.mode;
    assign dir      = q.dir;
    assign big_end  = q.be;
    assign tbl_addr = q.tbl;
    assign irq      = |q.sts;
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
    import dmac_pkg::*;
#(
    parameter int LEN_W = 17
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        halt,
    input  logic        start,
    input  logic [31:0] tbl_addr,
    input  logic        dir,
    input  logic        mem_ack,
    input  logic        mem_err,
    input  logic [31:0] mem_rdata,
    input  logic [31:0] rd_conv,
    input  logic [31:0] in_conv,
    input  logic        smp_out_ready,
    input  logic        smp_in_valid,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic        smp_out_valid,
    output logic [31:0] smp_out_data,
    output logic        smp_in_ready,
    output logic        idle,
    output logic [31:0] cur_ptr,
    output logic        ev_eop,
    output logic        ev_err,
    output logic        ev_stop
);
    localparam int LEFT_W = LEN_W - 2;

    typedef struct packed {
        dmac_st_e          st;
        logic [31:0]       desc;
        logic [31:0]       base;
        logic [31:0]       ptr;
        logic [LEFT_W-1:0] left;
        logic              eop;
        logic              eot;
        logic [31:0]       data;
        logic              hold;
    } eng_t;

    eng_t q, d;
    logic fire, done, fail;

    always_comb begin
        d       = q;
        done    = 1'b0;
        fail    = 1'b0;
        ev_eop  = 1'b0;
        ev_err  = 1'b0;
        ev_stop = 1'b0;

        mem_req = ((q.st == ST_DBASE) || (q.st == ST_DSIZE) ||
                   (q.st == ST_MRD)   || (q.st == ST_MWR)) && (run || q.hold);
        mem_we  = (q.st == ST_MWR);
        unique case (q.st)
            ST_DBASE: mem_addr = q.desc;
            ST_DSIZE: mem_addr = q.desc + 32'd4;
            default:  mem_addr = q.ptr;
        endcase
        mem_wdata     = q.data;
        smp_out_valid = (q.st == ST_SOUT) && run;
        smp_out_data  = q.data;
        smp_in_ready  = (q.st == ST_SIN) && run;
        idle          = (q.st == ST_IDLE);
        cur_ptr       = q.ptr;

        fire   = mem_req && mem_ack;
        d.hold = mem_req && !mem_ack;

        if ((q.st != ST_IDLE) && halt && !q.hold) begin
            d.st = ST_IDLE;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    if (start) begin
                        d.desc = tbl_addr;
                        d.st   = ST_DBASE;
                    end
                end
                ST_DBASE: begin
                    if (fire) begin
                        if (mem_err) fail = 1'b1;
                        else begin
                            d.base = mem_rdata;
                            d.st   = ST_DSIZE;
                        end
                    end
                end
                ST_DSIZE: begin
                    if (fire) begin
                        if (mem_err) fail = 1'b1;
                        else if (mem_rdata[FLG_JMP]) begin
                            d.desc = q.base;
                            d.st   = ST_DBASE;
                        end else if (mem_rdata[LEN_W-1:2] == '0) begin
                            fail = 1'b1;
                        end else begin
                            d.left = mem_rdata[LEN_W-1:2];
                            d.eop  = mem_rdata[FLG_EOP];
                            d.eot  = mem_rdata[FLG_EOT];
                            d.ptr  = q.base;
                            d.st   = dir ? ST_SIN : ST_MRD;
                        end
                    end
                end
                ST_MRD: begin
                    if (fire) begin
                        if (mem_err) fail = 1'b1;
                        else begin
                            d.data = rd_conv;
                            d.ptr  = q.ptr + 32'd4;
                            d.st   = ST_SOUT;
                        end
                    end
                end
                ST_SOUT: begin
                    if (smp_out_valid && smp_out_ready) begin
                        d.left = q.left - LEFT_W'(1);
                        if (q.left == LEFT_W'(1)) done = 1'b1;
                        else                      d.st = ST_MRD;
                    end
                end
                ST_SIN: begin
                    if (smp_in_valid && smp_in_ready) begin
                        d.data = in_conv;
                        d.st   = ST_MWR;
                    end
                end
                ST_MWR: begin
                    if (fire) begin
                        if (mem_err) fail = 1'b1;
                        else begin
                            d.ptr  = q.ptr + 32'd4;
                            d.left = q.left - LEFT_W'(1);
                            if (q.left == LEFT_W'(1)) done = 1'b1;
                            else                      d.st = ST_SIN;
                        end
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end

        if (done) begin
            ev_eop = q.eop || q.eot;
            if (q.eot) begin
                ev_stop = 1'b1;
                d.st    = ST_IDLE;
            end else begin
                d.desc = q.desc + 32'd8;
                d.st   = ST_DBASE;
            end
        end
        if (fail) begin
            ev_err  = 1'b1;
            ev_stop = 1'b1;
            d.st    = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
    import dmac_pkg::*;
#(
    parameter int LEN_W  = 17,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              smp_out_valid,
    input  logic              smp_out_ready,
    output logic [DATA_W-1:0] smp_out_data,
    input  logic              smp_in_valid,
    output logic              smp_in_ready,
    input  logic [DATA_W-1:0] smp_in_data
);
    logic [1:0]        mode;
    logic              dir, big_end, start, eng_idle;
    logic              ev_eop, ev_err, ev_stop;
    logic [31:0]       tbl_addr, cur_ptr;
    logic [DATA_W-1:0] rd_conv, in_conv;
    logic              run, halt;

    assign run  = (mode == MODE_RUN);
    assign halt = (mode != MODE_RUN) && (mode != MODE_PAUSE);

    dmac_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .eng_idle  (eng_idle),
        .ev_eop    (ev_eop),
        .ev_err    (ev_err),
        .ev_stop   (ev_stop),
        .cur_ptr   (cur_ptr),
        .mode      (mode),
        .dir       (dir),
        .big_end   (big_end),
        .tbl_addr  (tbl_addr),
        .start     (start),
        .irq       (irq)
    );

    dmac_swap #(.DATA_W(DATA_W)) u_swap_rd (
        .big_end (big_end),
        .din     (mem_rdata),
        .dout    (rd_conv)
    );

    dmac_swap #(.DATA_W(DATA_W)) u_swap_in (
        .big_end (big_end),
        .din     (smp_in_data),
        .dout    (in_conv)
    );

    dmac_engine #(.LEN_W(LEN_W)) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (run),
        .halt          (halt),
        .start         (start),
        .tbl_addr      (tbl_addr),
        .dir           (dir),
        .mem_ack       (mem_ack),
        .mem_err       (mem_err),
        .mem_rdata     (mem_rdata),
        .rd_conv       (rd_conv),
        .in_conv       (in_conv),
        .smp_out_ready (smp_out_ready),
        .smp_in_valid  (smp_in_valid),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .smp_out_valid (smp_out_valid),
        .smp_out_data  (smp_out_data),
        .smp_in_ready  (smp_in_ready),
        .idle          (eng_idle),
        .cur_ptr       (cur_ptr),
        .ev_eop        (ev_eop),
        .ev_err        (ev_err),
        .ev_stop       (ev_stop)
    );
endmodule

// File: rtl/dmac_channel_chk.sv
module dmac_channel_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  mode,
    input logic        ev_eop,
    input logic        ev_err,
    input logic        irq,
    input logic        reg_rd,
    input logic [1:0]  reg_addr,
    input logic        mem_req,
    input logic        mem_ack,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        smp_out_valid,
    input logic        smp_out_ready,
    input logic [31:0] smp_out_data,
    input logic        smp_in_ready
);
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_out_valid && !smp_out_ready |=> $stable(smp_out_data));

    assert_pause_streams_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |-> !smp_out_valid && !smp_in_ready);

    assert_pause_noreq_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) && !$past(mem_req && !mem_ack) |-> !mem_req);

    assert_err_stops_R14: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err |=> (mode == 2'b00));

    assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !(reg_rd && (reg_addr == 2'd1)) |=> irq);

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ev_eop || ev_err));
endmodule

bind dmac_channel dmac_channel_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode          (mode),
    .ev_eop        (ev_eop),
    .ev_err        (ev_err),
    .irq           (irq),
    .reg_rd        (reg_rd),
    .reg_addr      (reg_addr),
    .mem_req       (mem_req),
    .mem_ack       (mem_ack),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .smp_out_valid (smp_out_valid),
    .smp_out_ready (smp_out_ready),
    .smp_out_data  (smp_out_data),
    .smp_in_ready  (smp_in_ready)
);

// File: tb/dmac_channel_tb.sv
`timescale 1ns/1ps
module dmac_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0, reg_rdata;
    logic        irq;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        smp_out_valid, smp_out_ready = 1'b0;
    logic [31:0] smp_out_data;
    logic        smp_in_valid = 1'b0, smp_in_ready;
    logic [31:0] smp_in_data = 32'd0;

    always #2 clk = ~clk;

    dmac_channel dut_i (.*);

    int checks = 0;
    int errors = 0;
    int hs_cnt = 0;
    int cycles = 0;

    logic [31:0] mem_m [logic [31:0]];
    logic [31:0] exp_out [$];
    logic [31:0] exp_wa [$];
    logic [31:0] exp_wd [$];
    logic [31:0] src_q [$];
    logic [31:0] rd_log [$];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic        sink_en = 1'b1;
    logic        tog = 1'b0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = 32'd0;
    logic [31:0] rv;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    function automatic logic [31:0] sw(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    function automatic logic [31:0] rdm(input logic [31:0] a);
        if (mem_m.exists(a)) return mem_m[a];
        return pat(a);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // memory, sink and source models, evaluated between edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend) check(mem_req && (mem_addr == pend_addr), "R5 request held", mem_addr, pend_addr);
            tog       = ~tog;
            mem_ack   = mem_req && tog;
            mem_err   = mem_ack && (mem_addr == err_addr);
            mem_rdata = rdm(mem_addr);
            if (mem_ack && !mem_we) rd_log.push_back(mem_addr);
            if (mem_ack && mem_we && !mem_err) begin
                if (exp_wa.size() == 0) check(0, "R6 unexpected write", mem_addr, 32'd0);
                else begin
                    check(mem_addr == exp_wa[0], "R6 write address", mem_addr, exp_wa[0]);
                    check(mem_wdata == exp_wd[0], "R7 write data", mem_wdata, exp_wd[0]);
                    void'(exp_wa.pop_front());
                    void'(exp_wd.pop_front());
                end
                mem_m[mem_addr] = mem_wdata;
            end
            pend      = mem_req && !mem_ack;
            pend_addr = mem_addr;

            smp_out_ready = sink_en && (exp_out.size() > 0);
            if (smp_out_valid && smp_out_ready) begin
                hs_cnt++;
                check(smp_out_data == exp_out[0], "R4 output word", smp_out_data, exp_out[0]);
                void'(exp_out.pop_front());
            end

            smp_in_valid = (src_q.size() > 0);
            smp_in_data  = smp_in_valid ? src_q[0] : 32'd0;
            if (smp_in_valid && smp_in_ready) void'(src_q.pop_front());
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 3000 && !irq; i++) @(posedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_out_empty();
        for (int i = 0; i < 3000 && exp_out.size() > 0; i++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check(irq == 1'b0, "R1 irq", {31'd0, irq}, 32'd0);
        check(!mem_req && !smp_out_valid && !smp_in_ready, "R1 idle ports", {31'd0, mem_req}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            reg_read(2'(a), rv);
            check(rv == 32'd0, "R1 register zero", rv, 32'd0);
        end
        reg_write(2'd2, 32'h0000_ABC0);
        reg_read(2'd2, rv);
        check(rv == 32'h0000_ABC0, "R2 table readback", rv, 32'h0000_ABC0);

        // ring playback: two end-of-page blocks and a jump back
        mem_m[32'h1000] = 32'h2000; mem_m[32'h1004] = 32'h4000_0008;
        mem_m[32'h1008] = 32'h3000; mem_m[32'h100C] = 32'h4000_000C;
        mem_m[32'h1010] = 32'h1000; mem_m[32'h1014] = 32'h2000_0000;
        for (int p = 0; p < 2; p++) begin
            exp_out.push_back(pat(32'h2000)); exp_out.push_back(pat(32'h2004));
            exp_out.push_back(pat(32'h3000)); exp_out.push_back(pat(32'h3004));
            exp_out.push_back(pat(32'h3008));
        end
        rd_log.delete();
        reg_write(2'd2, 32'h1000);
        reg_write(2'd0, 32'h1);
        reg_read(2'd0, rv);
        check(rv == 32'h1, "R2 command readback", rv, 32'h1);
        wait_out_empty();
        check(exp_out.size() == 0, "R4 ring words delivered", exp_out.size(), 0);
        check(irq == 1'b1, "R8 irq on page end", {31'd0, irq}, 32'd1);
        reg_write(2'd0, 32'h0);
        repeat (10) @(negedge clk);
        check(!mem_req && !smp_out_valid, "R13 disable halts", {31'd0, mem_req}, 32'd0);
        check(rd_log[0] == 32'h1000 && rd_log[1] == 32'h1004, "R3 descriptor fetch order", rd_log[1], 32'h1004);
        check(rd_log[2] == 32'h2000, "R12 first data address", rd_log[2], 32'h2000);
        check(rd_log[4] == 32'h1008, "R8 next descriptor at +8", rd_log[4], 32'h1008);
        check(rd_log[11] == 32'h1000, "R9 jump to table start", rd_log[11], 32'h1000);
        reg_read(2'd1, rv);
        check(rv[0] == 1'b1, "R8 page status", rv, 32'h1);

        // pause and resume on an end-of-table block
        mem_m[32'h1100] = 32'h4000; mem_m[32'h1104] = 32'hC000_0020;
        for (int w = 0; w < 8; w++) exp_out.push_back(pat(32'h4000 + 32'(4 * w)));
        sink_en = 1'b0;
        reg_write(2'd2, 32'h1100);
        reg_write(2'd0, 32'h1);
        repeat (30) @(negedge clk);
        reg_write(2'd0, 32'h3);
        repeat (2) @(negedge clk);
        reg_read(2'd3, rv);
        check(rv == 32'h4004, "R12 pointer while paused", rv, 32'h4004);
        sink_en = 1'b1;
        begin
            int h0;
            h0 = hs_cnt;
            repeat (20) @(negedge clk);
            check(hs_cnt == h0 && !mem_req, "R13 paused is silent", hs_cnt - h0, 0);
        end
        reg_write(2'd0, 32'h1);
        wait_irq();
        check(exp_out.size() == 0, "R13 resume completes block", exp_out.size(), 0);
        reg_read(2'd0, rv);
        check(rv[1:0] == 2'b00, "R10 run state cleared", rv, 32'h0);
        reg_read(2'd1, rv);
        check(rv == 32'h1, "R10 end of table status", rv, 32'h1);
        check(irq == 1'b0, "R11 irq dropped after read", {31'd0, irq}, 32'd0);
        reg_read(2'd1, rv);
        check(rv == 32'h0, "R11 status cleared", rv, 32'h0);
        reg_read(2'd3, rv);
        check(rv == 32'h4020, "R12 pointer after block", rv, 32'h4020);
        check(!mem_req, "R10 no further requests", {31'd0, mem_req}, 32'd0);

        // record, big endian
        mem_m[32'h1200] = 32'h5000; mem_m[32'h1204] = 32'hC000_000C;
        src_q.push_back(32'h1122_3344); src_q.push_back(32'h5566_7788); src_q.push_back(32'h99AA_BBCC);
        exp_wa.push_back(32'h5000); exp_wd.push_back(32'h4433_2211);
        exp_wa.push_back(32'h5004); exp_wd.push_back(32'h8877_6655);
        exp_wa.push_back(32'h5008); exp_wd.push_back(32'hCCBB_AA99);
        reg_write(2'd2, 32'h1200);
        reg_write(2'd0, 32'hD);
        wait_irq();
        check(exp_wa.size() == 0, "R6 all record words written", exp_wa.size(), 0);
        check(rdm(32'h5008) == 32'hCCBB_AA99, "R7 record byte order", rdm(32'h5008), 32'hCCBB_AA99);
        reg_read(2'd1, rv);
        check(rv == 32'h1, "R10 record end status", rv, 32'h1);

        // playback, big endian
        mem_m[32'h1500] = 32'h8000; mem_m[32'h1504] = 32'h8000_0004;
        exp_out.push_back(sw(pat(32'h8000)));
        reg_write(2'd2, 32'h1500);
        reg_write(2'd0, 32'h5);
        wait_irq();
        check(exp_out.size() == 0, "R7 playback byte order", exp_out.size(), 0);
        reg_read(2'd1, rv);
        check(rv == 32'h1, "R10 single word status", rv, 32'h1);

        // short count error
        mem_m[32'h1300] = 32'h6000; mem_m[32'h1304] = 32'h0000_0002;
        begin
            int h0;
            h0 = hs_cnt;
            reg_write(2'd2, 32'h1300);
            reg_write(2'd0, 32'h1);
            wait_irq();
            check(hs_cnt == h0, "R14 no data on short count", hs_cnt - h0, 0);
        end
        reg_read(2'd1, rv);
        check(rv == 32'h2, "R14 short count error", rv, 32'h2);
        reg_read(2'd0, rv);
        check(rv[1:0] == 2'b00, "R14 stopped after short count", rv, 32'h0);

        // memory error mid-block
        mem_m[32'h1400] = 32'h7000; mem_m[32'h1404] = 32'h8000_0008;
        exp_out.push_back(pat(32'h7000));
        err_addr = 32'h7004;
        reg_write(2'd2, 32'h1400);
        reg_write(2'd0, 32'h1);
        wait_irq();
        repeat (4) @(negedge clk);
        err_addr = 32'hFFFF_FFFF;
        check(exp_out.size() == 0, "R14 words before error", exp_out.size(), 0);
        reg_read(2'd1, rv);
        check(rv == 32'h2, "R14 memory error status", rv, 32'h2);
        reg_read(2'd0, rv);
        check(rv[1:0] == 2'b00, "R14 stopped after memory error", rv, 32'h0);
        check(!mem_req, "R14 no requests after error", {31'd0, mem_req}, 32'd0);

        summary();
    end
endmodule